// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block turns bytes written into a sixteen-entry queue into asynchronous serial frames on a single output line. The frame shape is set by static configuration inputs: the number of data bits (5 to 8), whether a parity bit is appended and which polarity it uses, and whether the frame ends with one or two stop periods. Bit timing comes from an external rate generator that pulses a one-cycle enable once per bit period. The block advances its line state only on those pulses.

A producer writes characters through a simple write strobe and watches a full flag. A queued character is lost if it is written while the queue is full. Frames leave back to back for as long as the transmitter is enabled and characters remain queued. A busy output covers both queued characters and the frame on the wire. It stays meaningful while the transmitter is disabled. A level output tells the producer that the queue has drained to or below a selectable fraction of its depth, so it can refill in bursts.

Top module: `serial_tx_top`

## Requirements
- R1: A frame is one low start period, then the data bits least significant first, then the parity bit if enabled, then the stop period(s) at high level; each period lasts from one `bit_tick` to the next.
- R2: `cfg_len` selects the data length: code 0 sends 5 bits, 1 sends 6, 2 sends 7 and 3 sends 8; higher data bits of the byte are not sent.
- R3: `cfg_stop2` at 0 gives one high stop period; at 1 it gives two.
- R4: With `cfg_par_en` set, the parity bit makes the count of ones over the sent data bits plus parity even when `cfg_par_odd` is 0 and odd when it is 1.
- R5: A frame starts on a `bit_tick` only while `enable` is high and the queue holds a character. When the queue still holds a character as a frame ends, the next start bit follows the last stop period with no idle period between them.
- R6: `busy` is high from the cycle after an accepted write until the queue is empty and the final stop period of the last frame has ended, regardless of `enable`.
- R7: The queue holds 16 characters. `full` is high at 16. A write while full is dropped and that character is never sent.
- R8: `level_hit` is high when the queue occupancy is at or below the selected level. `cfg_level` code 0 selects 2 entries, 1 selects 4, 2 selects 8, 3 selects 12, and 4 to 7 select 14.
- R9: `tx` is high whenever no frame is in progress. While `enable` is low, no new frame starts.
- R10: After reset, `tx` is high, `busy` and `full` are low, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par_en | input | 1 | Append parity bit |
| cfg_par_odd | input | 1 | Parity polarity: 1 odd, 0 even |
| cfg_stop2 | input | 1 | Two stop periods when 1 |
| cfg_level | input | 3 | Level trigger selection |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Character to queue |
| full | output | 1 | Queue holds 16 characters |
| busy | output | 1 | Queue or frame still active |
| level_hit | output | 1 | Occupancy at or below selected level |
| tx | output | 1 | Serial output line |

## Verification
Random bursts of characters are sent under random combinations of length, parity and stop settings. Every line period is decoded against a bench model, which separates errors in bit order and masking from errors in parity polarity and stop count. A directed fill to sixteen entries with the transmitter disabled, followed by an overfill, checks every occupancy against each level code and shows that a refused character never appears. The drain that follows checks that frames run back to back and that busy falls only after the last stop period. A disabled window with characters queued shows whether a frame can start while the transmitter is off.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } fmt_t;

    function automatic int unsigned level_of(input logic [2:0] sel, input int unsigned depth);
        case (sel)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return (depth * 3) / 4;
            default: return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } qst_t;

    qst_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[st_q.rp];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= push_data;
    end

    // R7: occupancy never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R7: a write into a full queue without a read leaves it full
    a_r7_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(st_q.wp)));

endmodule

// File: rtl/tx_level.sv
module tx_level #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [2:0]    sel,
    output logic          hit
);
    import serial_tx_pkg::*;

    logic [CW-1:0] lvl;

    always_comb begin
        lvl = CW'(level_of(sel, DEPTH));
        hit = (count <= lvl);
    end

    // R8: a full queue is above every selectable level
    a_r8_full_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !hit);

    // R8: an empty queue always counts as at or below the level
    a_r8_empty_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> hit);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tick,
    input  logic                 q_empty,
    input  logic [DW-1:0]        q_head,
    input  serial_tx_pkg::fmt_t  fmt_in,
    output logic                 pop,
    output logic                 active,
    output logic                 tx
);
    import serial_tx_pkg::*;

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] sh;
        logic [2:0]    idx;
        logic          par;
        fmt_t          fmt;
        logic          line;
    } sst_t;

    sst_t st_d, st_q;
    logic [DW-1:0] mask;
    logic [2:0]    last_idx;
    logic          can_start;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < 5 + int'(fmt_in.len)) mask[i] = 1'b1;
        end
    end

    assign last_idx  = 3'd4 + 3'(st_q.fmt.len);
    assign can_start = tick && enable && !q_empty;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                st_d.line = 1'b1;
                if (can_start) begin
                    pop       = 1'b1;
                    st_d.ph   = PH_START;
                    st_d.sh   = q_head;
                    st_d.fmt  = fmt_in;
                    st_d.par  = (^(q_head & mask)) ^ fmt_in.par_odd;
                    st_d.idx  = '0;
                    st_d.line = 1'b0;
                end
            end
            PH_START: begin
                if (tick) begin
                    st_d.ph   = PH_DATA;
                    st_d.line = st_q.sh[0];
                    st_d.sh   = st_q.sh >> 1;
                    st_d.idx  = '0;
                end
            end
            PH_DATA: begin
                if (tick) begin
                    if (st_q.idx == last_idx) begin
                        st_d.idx = '0;
                        if (st_q.fmt.par_en) begin
                            st_d.ph   = PH_PAR;
                            st_d.line = st_q.par;
                        end else begin
                            st_d.ph   = PH_STOP;
                            st_d.line = 1'b1;
                        end
                    end else begin
                        st_d.idx  = st_q.idx + 1'b1;
                        st_d.line = st_q.sh[0];
                        st_d.sh   = st_q.sh >> 1;
                    end
                end
            end
            PH_PAR: begin
                if (tick) begin
                    st_d.ph   = PH_STOP;
                    st_d.line = 1'b1;
                    st_d.idx  = '0;
                end
            end
            PH_STOP: begin
                if (tick) begin
                    if (st_q.fmt.stop2 && st_q.idx == '0) begin
                        st_d.idx = 3'd1;
                    end else if (can_start) begin
                        pop       = 1'b1;
                        st_d.ph   = PH_START;
                        st_d.sh   = q_head;
                        st_d.fmt  = fmt_in;
                        st_d.par  = (^(q_head & mask)) ^ fmt_in.par_odd;
                        st_d.idx  = '0;
                        st_d.line = 1'b0;
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.line = 1'b1;
                    end
                end
            end
            default: begin
                st_d.ph   = PH_IDLE;
                st_d.line = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.ph != PH_IDLE);
    assign tx     = st_q.line;

    // R1: taking a character puts a low start period on the line next cycle
    a_r1_start_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !tx);

    // R5 / R9: a character is taken only on a tick while enabled
    a_r5_pop_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (enable && tick && !q_empty));

    // R9: line is high whenever no frame is running
    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> tx);

    // R1: the line only moves on a tick edge
    a_r1_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tx));

endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          bit_tick,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    input  logic [2:0]    cfg_level,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          busy,
    output logic          level_hit,
    output logic          tx
);
    import serial_tx_pkg::*;

    logic          q_pop, q_empty, active;
    logic [DW-1:0] q_head;
    logic [CW-1:0] q_count;
    fmt_t          fmt;

    always_comb begin
        fmt.len     = cfg_len;
        fmt.par_en  = cfg_par_en;
        fmt.par_odd = cfg_par_odd;
        fmt.stop2   = cfg_stop2;
    end

    tx_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en), .push_data(wr_data), .pop(q_pop),
        .head(q_head), .empty(q_empty), .full(full), .count(q_count)
    );

    tx_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(bit_tick),
        .q_empty(q_empty), .q_head(q_head), .fmt_in(fmt),
        .pop(q_pop), .active(active), .tx(tx)
    );

    tx_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst_n(rst_n), .count(q_count), .sel(cfg_level), .hit(level_hit)
    );

    assign busy = !q_empty || active;

    // R6: an accepted write makes busy visible on the next cycle
    a_r6_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> busy);

    // R6: busy cannot drop while a frame is still on the line
    a_r6_busy_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

endmodule

// File: tb/serial_tx_top_bench.sv
module serial_tx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic [2:0] cfg_level = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       full, busy, level_hit, tx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int tick_samples = 0;
    int tcnt = 0;

    logic [7:0] exp_q[$];
    int         ms = 0;
    int         bi = 0;
    int         si = 0;
    logic [7:0] cur;
    logic       b2b_en = 1'b0;
    logic       b2b_pend = 1'b0;

    serial_tx_top u_serial_tx_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_level(cfg_level), .wr_en(wr_en),
        .wr_data(wr_data), .full(full), .busy(busy), .level_hit(level_hit), .tx(tx)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    function automatic int nbits(input logic [1:0] l);
        return 5 + int'(l);
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] l, input logic odd);
        logic p = odd;
        for (int i = 0; i < 8; i++) if (i < nbits(l)) p ^= d[i];
        return p;
    endfunction

    function automatic int exp_level(input logic [2:0] s);
        case (s)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            default: return 14;
        endcase
    endfunction

    // tick generator and line decoder; sample point is the falling edge after a tick edge
    always @(negedge clk) begin
        if (rst_n && bit_tick) begin
            tick_samples++;
            case (ms)
                0: begin
                    if (b2b_pend) chk(tx == 1'b0, "R5 back-to-back start", int'(tx), 0);
                    b2b_pend = 1'b0;
                    if (tx == 1'b0) begin
                        chk(exp_q.size() != 0, "R9 frame with nothing queued", 0, 1);
                        if (exp_q.size() != 0) cur = exp_q.pop_front();
                        ms = 1;
                        bi = 0;
                    end
                end
                1: begin
                    chk(tx == cur[bi], "R1 R2 data bit", int'(tx), int'(cur[bi]));
                    bi++;
                    if (bi == nbits(cfg_len)) begin
                        ms = cfg_par_en ? 2 : 3;
                        si = 0;
                    end
                end
                2: begin
                    chk(tx == exp_par(cur, cfg_len, cfg_par_odd), "R4 parity bit",
                        int'(tx), int'(exp_par(cur, cfg_len, cfg_par_odd)));
                    ms = 3;
                end
                default: begin
                    chk(tx == 1'b1, "R3 stop level", int'(tx), 1);
                    chk(busy == 1'b1, "R6 busy in stop", int'(busy), 1);
                    si++;
                    if (si == (cfg_stop2 ? 2 : 1)) begin
                        ms = 0;
                        b2b_pend = b2b_en && enable && (exp_q.size() != 0);
                    end
                end
            endcase
        end
        tcnt = (tcnt == 3) ? 0 : tcnt + 1;
        bit_tick = (tcnt == 3);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic put(input logic [7:0] d, input logic expect_ok);
        wr_en   = 1'b1;
        wr_data = d;
        if (expect_ok) exp_q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0 || ms != 0) @(negedge clk);
        begin
            int s0 = tick_samples;
            while (tick_samples == s0) @(negedge clk);
        end
        @(negedge clk);
        chk(busy == 1'b0, "R6 busy low after last stop", int'(busy), 0);
        chk(tx == 1'b1, "R9 idle line high", int'(tx), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(tx == 1'b1, "R10 reset tx", int'(tx), 1);
        chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
        chk(full == 1'b0, "R10 reset full", int'(full), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // disabled: queued characters must not start a frame, busy still valid
        enable = 1'b0;
        put(8'hA5, 1'b1);
        chk(busy == 1'b1, "R6 busy after write while disabled", int'(busy), 1);
        begin
            logic stayed_high = 1'b1;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (tx !== 1'b1) stayed_high = 1'b0;
            end
            chk(stayed_high, "R9 no frame while disabled", int'(stayed_high), 1);
        end
        chk(busy == 1'b1, "R6 busy held while disabled", int'(busy), 1);
        enable = 1'b1;
        wait_done();

        // fill, overfill and back-to-back drain per level code
        for (int sel = 0; sel < 5; sel++) begin
            enable      = 1'b0;
            cfg_level   = 3'(sel);
            cfg_len     = 2'(sel % 4);
            cfg_par_en  = sel[0];
            cfg_par_odd = sel[1];
            cfg_stop2   = sel[2] | sel[0];
            @(negedge clk);
            chk(level_hit == 1'b1, "R8 empty level", int'(level_hit), 1);
            for (int k = 1; k <= 16; k++) begin
                put(8'($urandom()), 1'b1);
                chk(level_hit == (k <= exp_level(3'(sel))), "R8 level at occupancy",
                    int'(level_hit), int'(k <= exp_level(3'(sel))));
                chk(full == (k == 16), "R7 full flag", int'(full), int'(k == 16));
            end
            put(8'hFF, 1'b0);
            chk(full == 1'b1, "R7 full after refused write", int'(full), 1);
            b2b_en = 1'b1;
            enable = 1'b1;
            wait_done();
            b2b_en = 1'b0;
            chk(full == 1'b0, "R7 drained", int'(full), 0);
        end

        // random formats and bursts
        for (int r = 0; r < 12; r++) begin
            int n;
            cfg_len     = 2'($urandom_range(0, 3));
            cfg_par_en  = 1'($urandom_range(0, 1));
            cfg_par_odd = 1'($urandom_range(0, 1));
            cfg_stop2   = 1'($urandom_range(0, 1));
            enable      = 1'b1;
            n = $urandom_range(1, 12);
            for (int j = 0; j < n; j++) begin
                while (exp_q.size() >= 14) @(negedge clk);
                put(8'($urandom()), 1'b1);
                repeat ($urandom_range(0, 40)) @(negedge clk);
            end
            wait_done();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule